// File: doc/BRIEF.md
# Multi-Mode GPIO Pin Function Unit

This unit runs one pin of a timer-linked general-purpose I/O block. A 4-bit mode field decides what the pin does. As an input, the pin can simply be read. It can also latch the value of a chosen time base when it sees an edge or a level, and raise a one-cycle interrupt pulse when it does. As an output, the pin can be held low or high, can follow a line bit from software, can produce pulse-width modulation against a chosen counter, or can play a bit pattern held in the threshold register.

The surrounding block supplies the following: the counter values, their count direction, their sawtooth or triangle shape, the global system time, the threshold/capture register contents, and a clear strobe for the pin interrupt. A single invert bit flips both the sampled input and the driven output. The register file and the counters are outside this unit.

Top module: `gpio_pin_unit`

## Requirements
- R1: Only modes 4 to 8 (decimal) enable the output. All other codes, including 0 (read), 1 to 3 (capture) and 9 to 15, keep `pin_oe_o` low. `pin_oe_o` follows the mode one clock later. After reset every output is 0.
- R2: Mode 4 drives level 0, mode 5 drives level 1, and mode 6 drives `line_i`. The driven level is XORed with `inv_i` and appears on `pin_o` one clock after the inputs.
- R3: `pin_i` passes through a two-flop synchronizer and is XORed with `inv_i`. The result appears on `pin_lvl_o` on the third rising clock edge after `pin_i` changes. With `inv_i` set, a falling pin counts as a rising edge.
- R4: `cnt_sel_i` picks the time base: 0, 1 and 2 pick counter slices 0, 1 and 2 of `cnt_val_i` (slice k is bits [32k+31:32k]), and 3 picks `sys_time_i`.
- R5: In mode 1, every rising edge of the sampled input copies the selected time base into `cap_data_o` and pulses `irq_o` for one clock. Both appear on the same edge that first shows the new level on `pin_lvl_o`. `cap_data_o` never changes without an `irq_o` pulse.
- R6: Mode 2 captures on a rising edge only while armed. Each capture disarms the unit. A one-cycle `irq_irq_clr_i` pulse re-arms it. Reset leaves the unit armed.
- R7: Mode 3 captures while the sampled input is high and the unit is armed, then disarms. It captures only once until the next clear.
- R8: A clear in a cycle where no capture is taken re-arms the unit for the next cycle. A clear in the same cycle as a capture loses: the capture is taken and the unit stays disarmed.
- R9: In mode 7 with a sawtooth time base, the level is active when the counter is greater than or equal to the threshold. Threshold changes take effect in the next cycle. The system time counts as a sawtooth time base.
- R10: In mode 7 with a triangle time base, the counter is compared with threshold bits [31:1]. When threshold bit 0 is set and the counter counts up, the counter must be strictly greater than that value for the level to be active.
- R11: In mode 8, the output level is threshold bit `idx`, with `idx` starting at 0 on entry to the mode. `idx` advances each time the selected time base goes from a nonzero value to 0. After bit `blink_len_i` it returns to 0.
- R12: In mode 8 with `blink_once_i` set, the wrap after the last pattern bit ends the sequence. The driven level then stays 0 until the mode is left and entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous pin input |
| mode_i | input | 4 | Pin mode code |
| inv_i | input | 1 | Invert input and output |
| cnt_sel_i | input | 2 | Time base select (3 = system time) |
| blink_len_i | input | 5 | Number of pattern bits minus one |
| blink_once_i | input | 1 | Play the pattern a single time |
| thr_i | input | 32 | Threshold / pattern register contents |
| cnt_val_i | input | 96 | Three packed counter values |
| cnt_up_i | input | 3 | Counter counting up, one bit per counter |
| cnt_sym_i | input | 3 | Counter in triangle mode, one bit per counter |
| sys_time_i | input | 32 | Global system time |
| line_i | input | 1 | Software line bit |
| irq_clr_i | input | 1 | Pin interrupt cleared, re-arms single capture |
| pin_o | output | 1 | Registered pin output level |
| pin_oe_o | output | 1 | Registered output enable |
| pin_lvl_o | output | 1 | Registered sampled input level |
| cap_data_o | output | 32 | Captured time base value |
| irq_o | output | 1 | One-cycle capture interrupt pulse |

## Verification
The clear strobe and a single-shot capture can land on the same clock. The race is easiest to see in the high-level mode. With the pin held high and the unit disarmed, the bench holds the clear strobe for two clocks. The first clock only re-arms the unit. The second clock is then both a capture and a clear. The bench judges the result in the next cycles by changing the counter value. If the capture had not won, a second interrupt would show up carrying the new value. The bench expects exactly one pulse, and the captured value stays the one taken with the clear.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  typedef enum logic [3:0] {
    PM_READ      = 4'd0,
    PM_CAP_EACH  = 4'd1,
    PM_CAP_EDGE1 = 4'd2,
    PM_CAP_LVL1  = 4'd3,
    PM_DRV_LO    = 4'd4,
    PM_DRV_HI    = 4'd5,
    PM_LINE      = 4'd6,
    PM_PWM       = 4'd7,
    PM_BLINK     = 4'd8
  } pin_mode_e;

  function automatic logic is_out_mode(input logic [3:0] m);
    return (m >= PM_DRV_LO) && (m <= PM_BLINK);
  endfunction

  function automatic logic is_once_mode(input logic [3:0] m);
    return (m == PM_CAP_EDGE1) || (m == PM_CAP_LVL1);
  endfunction

endpackage

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic inv_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign lvl_o = sync_q[SYNC_STAGES-1] ^ inv_i;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~prev_q;

endmodule

// File: rtl/gpio_ref_mux.sv
module gpio_ref_mux #(
  parameter int W    = 32,
  parameter int NCNT = 3,
  localparam int SELW = $clog2(NCNT + 1)
) (
  input  logic [SELW-1:0]   sel_i,
  input  logic [NCNT*W-1:0] cnt_val_i,
  input  logic [NCNT-1:0]   cnt_up_i,
  input  logic [NCNT-1:0]   cnt_sym_i,
  input  logic [W-1:0]      sys_time_i,
  output logic [W-1:0]      val_o,
  output logic              up_o,
  output logic              sym_o
);

  always_comb begin
    val_o = sys_time_i;
    up_o  = 1'b1;
    sym_o = 1'b0;
    for (int i = 0; i < NCNT; i++) begin
      if (sel_i == SELW'(i)) begin
        val_o = cnt_val_i[i*W +: W];
        up_o  = cnt_up_i[i];
        sym_o = cnt_sym_i[i];
      end
    end
  end

endmodule

// File: rtl/gpio_capture.sv
module gpio_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   mode_i,
  input  logic         lvl_i,
  input  logic         rise_i,
  input  logic [W-1:0] ref_i,
  input  logic         clr_i,
  output logic [W-1:0] cap_o,
  output logic         irq_o
);

  logic armed_q;
  logic take;

  always_comb begin
    unique case (mode_i)
      gpio_pin_pkg::PM_CAP_EACH:  take = rise_i;
      gpio_pin_pkg::PM_CAP_EDGE1: take = rise_i & armed_q;
      gpio_pin_pkg::PM_CAP_LVL1:  take = lvl_i & armed_q;
      default:                    take = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_o   <= '0;
      irq_o   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      irq_o <= take;
      if (take) cap_o <= ref_i;
      if (take && gpio_pin_pkg::is_once_mode(mode_i)) armed_q <= 1'b0;
      else if (clr_i)                                armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/gpio_pwm_cmp.sv
module gpio_pwm_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] thr_i,
  input  logic         sym_i,
  input  logic         up_i,
  output logic         act_o
);

  logic [W-1:0] half_thr;

  assign half_thr = thr_i >> 1;

  always_comb begin
    if (!sym_i)               act_o = (val_i >= thr_i);
    else if (up_i && thr_i[0]) act_o = (val_i > half_thr);
    else                       act_o = (val_i >= half_thr);
  end

endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
  parameter int W = 32,
  localparam int LENW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic [W-1:0]    ref_i,
  input  logic [LENW-1:0] len_i,
  input  logic            once_i,
  input  logic [W-1:0]    pat_i,
  output logic            lvl_o
);

  logic [LENW-1:0] idx_q;
  logic            done_q;
  logic [W-1:0]    prev_q;
  logic            wrap;

  assign wrap = (ref_i == '0) && (prev_q != '0);

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= ref_i;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (wrap && !done_q) begin
      if (idx_q == len_i) begin
        if (once_i) done_q <= 1'b1;
        else        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign lvl_o = done_q ? 1'b0 : pat_i[idx_q];

endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit #(
  parameter int W           = 32,
  parameter int NCNT        = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SELW = $clog2(NCNT + 1),
  localparam int LENW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_i,
  input  logic [3:0]        mode_i,
  input  logic              inv_i,
  input  logic [SELW-1:0]   cnt_sel_i,
  input  logic [LENW-1:0]   blink_len_i,
  input  logic              blink_once_i,
  input  logic [W-1:0]      thr_i,
  input  logic [NCNT*W-1:0] cnt_val_i,
  input  logic [NCNT-1:0]   cnt_up_i,
  input  logic [NCNT-1:0]   cnt_sym_i,
  input  logic [W-1:0]      sys_time_i,
  input  logic              line_i,
  input  logic              irq_clr_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              pin_lvl_o,
  output logic [W-1:0]      cap_data_o,
  output logic              irq_o
);

  logic         in_lvl, in_rise;
  logic [W-1:0] ref_val;
  logic         ref_up, ref_sym;
  logic         pwm_act, blink_lvl;
  logic         drv_lvl;

  gpio_in_stage #(.SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst(rst), .pin_i(pin_i), .inv_i(inv_i),
    .lvl_o(in_lvl), .rise_o(in_rise)
  );

  gpio_ref_mux #(.W(W), .NCNT(NCNT)) u_mux (
    .sel_i(cnt_sel_i), .cnt_val_i(cnt_val_i), .cnt_up_i(cnt_up_i),
    .cnt_sym_i(cnt_sym_i), .sys_time_i(sys_time_i),
    .val_o(ref_val), .up_o(ref_up), .sym_o(ref_sym)
  );

  gpio_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .mode_i(mode_i), .lvl_i(in_lvl), .rise_i(in_rise),
    .ref_i(ref_val), .clr_i(irq_clr_i), .cap_o(cap_data_o), .irq_o(irq_o)
  );

  gpio_pwm_cmp #(.W(W)) u_pwm (
    .val_i(ref_val), .thr_i(thr_i), .sym_i(ref_sym), .up_i(ref_up),
    .act_o(pwm_act)
  );

  gpio_blink #(.W(W)) u_blink (
    .clk(clk), .rst(rst), .en_i(mode_i == gpio_pin_pkg::PM_BLINK),
    .ref_i(ref_val), .len_i(blink_len_i), .once_i(blink_once_i),
    .pat_i(thr_i), .lvl_o(blink_lvl)
  );

  always_comb begin
    unique case (mode_i)
      gpio_pin_pkg::PM_DRV_HI: drv_lvl = 1'b1;
      gpio_pin_pkg::PM_LINE:   drv_lvl = line_i;
      gpio_pin_pkg::PM_PWM:    drv_lvl = pwm_act;
      gpio_pin_pkg::PM_BLINK:  drv_lvl = blink_lvl;
      default:                 drv_lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o     <= 1'b0;
      pin_oe_o  <= 1'b0;
      pin_lvl_o <= 1'b0;
    end else begin
      pin_oe_o  <= gpio_pin_pkg::is_out_mode(mode_i);
      pin_o     <= gpio_pin_pkg::is_out_mode(mode_i) ? (drv_lvl ^ inv_i) : 1'b0;
      pin_lvl_o <= in_lvl;
    end
  end

endmodule

// File: rtl/gpio_pin_unit_chk.sv
module gpio_pin_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   mode_i,
  input logic         inv_i,
  input logic [1:0]   cnt_sel_i,
  input logic [W-1:0] thr_i,
  input logic [W-1:0] sys_time_i,
  input logic         pin_o,
  input logic         pin_oe_o,
  input logic         irq_o,
  input logic [W-1:0] cap_data_o
);

  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i <= 4'd3) |=> !pin_oe_o);

  // R2
  drv_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'd4) |=> (pin_oe_o && (pin_o == $past(inv_i))));

  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(mode_i) >= 4'd1 && $past(mode_i) <= 4'd3));

  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> $stable(cap_data_o));

  // R9
  saw_systime_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'd7 && cnt_sel_i == 2'd3 && sys_time_i >= thr_i)
      |=> (pin_o != $past(inv_i)));

endmodule

bind gpio_pin_unit gpio_pin_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .inv_i(inv_i),
  .cnt_sel_i(cnt_sel_i), .thr_i(thr_i), .sys_time_i(sys_time_i),
  .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o), .cap_data_o(cap_data_o)
);

// File: tb/gpio_pin_unit_tb.sv
module gpio_pin_unit_tb;
  localparam int W = 32;
  localparam int NC = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst, pin, inv, once, line, clr;
  logic [3:0]      mode;
  logic [1:0]      sel;
  logic [4:0]      len;
  logic [W-1:0]    thr, sys_time;
  logic [NC*W-1:0] cnt_val;
  logic [NC-1:0]   cnt_up, cnt_sym;
  logic            pin_o, pin_oe, pin_lvl, irq;
  logic [W-1:0]    cap;

  gpio_pin_unit u_dut (
    .clk(clk), .rst(rst), .pin_i(pin), .mode_i(mode), .inv_i(inv),
    .cnt_sel_i(sel), .blink_len_i(len), .blink_once_i(once), .thr_i(thr),
    .cnt_val_i(cnt_val), .cnt_up_i(cnt_up), .cnt_sym_i(cnt_sym),
    .sys_time_i(sys_time), .line_i(line), .irq_clr_i(clr),
    .pin_o(pin_o), .pin_oe_o(pin_oe), .pin_lvl_o(pin_lvl),
    .cap_data_o(cap), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_cnt(input int i, input logic [W-1:0] v);
    cnt_val[i*W +: W] = v;
  endtask

  task automatic make_rise();
    pin = 1'b0;
    repeat (3) tick();
    pin = 1'b1;
    repeat (3) tick();
  endtask

  function automatic logic pwm_exp(input logic [W-1:0] c, input logic [W-1:0] t,
                                   input logic sym, input logic up);
    if (!sym) return c >= t;
    if (up && t[0]) return c > (t >> 1);
    return c >= (t >> 1);
  endfunction

  task automatic run_blink(input int steps, input string req);
    int idx = 0;
    bit done = 0;
    logic [W-1:0] prev = '0;
    for (int s = 0; s < steps; s++) begin
      logic [W-1:0] cur;
      logic exp;
      cur = W'((s + 1) % 3);
      set_cnt(1, cur);
      exp = done ? 1'b0 : thr[idx];
      if (cur == 0 && prev != 0 && !done) begin
        if (idx == int'(len)) begin
          if (once) done = 1;
          else      idx = 0;
        end else begin
          idx++;
        end
      end
      prev = cur;
      tick();
      chk(req, W'(pin_o), W'(exp ^ inv), "blink level");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; pin = 0; inv = 0; once = 0; line = 0; clr = 0;
    mode = 4'd0; sel = 2'd0; len = 5'd0; thr = '0; sys_time = '0;
    cnt_val = '0; cnt_up = '0; cnt_sym = '0;
    repeat (4) tick();
    rst = 0;
    // R1 reset state
    chk("R1", W'(pin_oe), 0, "oe after reset");
    chk("R1", W'(pin_o), 0, "pin after reset");
    chk("R1", W'(irq), 0, "irq after reset");
    chk("R1", cap, 0, "cap after reset");

    // R2 fixed drives
    mode = 4'd4; tick();
    chk("R2", W'({pin_oe, pin_o}), 2'b10, "drive low");
    mode = 4'd5; tick();
    chk("R2", W'({pin_oe, pin_o}), 2'b11, "drive high");
    mode = 4'd6; line = 1; tick();
    chk("R2", W'(pin_o), 1, "line bit 1");
    line = 0; tick();
    chk("R2", W'(pin_o), 0, "line bit 0");
    mode = 4'd5; inv = 1; tick();
    chk("R2", W'(pin_o), 0, "inverted high");
    inv = 0; mode = 4'd0; tick();
    chk("R1", W'(pin_oe), 0, "read mode oe");
    mode = 4'd11; tick();
    chk("R1", W'(pin_oe), 0, "unused code oe");
    mode = 4'd0;

    // R3 input latency and inversion
    pin = 1; tick(); tick();
    chk("R3", W'(pin_lvl), 0, "level before third edge");
    tick();
    chk("R3", W'(pin_lvl), 1, "level at third edge");
    inv = 1; tick();
    chk("R3", W'(pin_lvl), 0, "inverted level");
    inv = 0; pin = 0; repeat (3) tick();

    // R5 continuous capture
    mode = 4'd1; sel = 2'd0; set_cnt(0, 100);
    make_rise();
    chk("R5", W'(irq), 1, "irq on first edge");
    chk("R5", cap, 100, "first capture");
    tick();
    chk("R5", W'(irq), 0, "irq is a pulse");
    set_cnt(0, 200);
    make_rise();
    chk("R5", W'(irq), 1, "irq on second edge");
    chk("R5", cap, 200, "second capture");

    // R4 time base selection
    sel = 2'd2; set_cnt(2, 333); make_rise();
    chk("R4", cap, 333, "counter 2");
    sel = 2'd1; set_cnt(1, 111); make_rise();
    chk("R4", cap, 111, "counter 1");
    sel = 2'd3; sys_time = 444; make_rise();
    chk("R4", cap, 444, "system time");
    sel = 2'd0;

    // R3 inverted edge: falling pin captures
    mode = 4'd0; inv = 1; pin = 1; repeat (3) tick();
    mode = 4'd1; set_cnt(0, 555); pin = 0; repeat (3) tick();
    chk("R3", W'(irq), 1, "falling pin with invert");
    chk("R3", cap, 555, "inverted capture value");
    mode = 4'd0; inv = 0; pin = 0; repeat (3) tick();

    // R6 capture once on edge
    mode = 4'd2; set_cnt(0, 10); make_rise();
    chk("R6", cap, 10, "first single capture");
    chk("R6", W'(irq), 1, "first single irq");
    set_cnt(0, 20); make_rise();
    chk("R6", W'(irq), 0, "frozen irq");
    chk("R6", cap, 10, "frozen value");
    clr = 1; tick(); clr = 0;
    set_cnt(0, 30); make_rise();
    chk("R6", cap, 30, "rearmed capture");

    // R7 capture once on high level
    mode = 4'd0; pin = 0; repeat (3) tick();
    clr = 1; tick(); clr = 0;
    mode = 4'd3; set_cnt(0, 50); pin = 1; repeat (3) tick();
    chk("R7", W'(irq), 1, "level capture irq");
    chk("R7", cap, 50, "level capture value");
    tick();
    chk("R7", W'(irq), 0, "no repeat while high");
    set_cnt(0, 60); tick(); tick();
    chk("R7", cap, 50, "value held while high");

    // R8 clear alone, then clear racing a capture
    clr = 1; tick();
    chk("R8", W'(irq), 0, "clear cycle has no capture");
    clr = 0; tick();
    chk("R8", W'(irq), 1, "capture after clear");
    chk("R8", cap, 60, "value after clear");
    set_cnt(0, 70); clr = 1; tick();
    chk("R8", W'(irq), 0, "rearm cycle");
    tick();
    chk("R8", W'(irq), 1, "capture with clear");
    chk("R8", cap, 70, "value with clear");
    clr = 0; set_cnt(0, 80); tick();
    chk("R8", W'(irq), 0, "capture wins over clear");
    tick();
    chk("R8", cap, 70, "no second capture");
    mode = 4'd0; pin = 0; repeat (3) tick();

    // R9 sawtooth PWM
    mode = 4'd7; sel = 2'd0; cnt_sym = '0; thr = 5;
    set_cnt(0, 4); tick(); chk("R9", W'(pin_o), 0, "below threshold");
    set_cnt(0, 5); tick(); chk("R9", W'(pin_o), 1, "equal threshold");
    thr = 6; tick(); chk("R9", W'(pin_o), 0, "threshold raised at once");
    thr = 0; set_cnt(0, 0); tick(); chk("R9", W'(pin_o), 1, "zero threshold");

    // R10 triangle PWM
    cnt_sym = 3'b001; thr = 7;
    cnt_up = 3'b001; set_cnt(0, 3); tick(); chk("R10", W'(pin_o), 0, "up at half, lsb set");
    cnt_up = 3'b000; tick(); chk("R10", W'(pin_o), 1, "down at half");
    cnt_up = 3'b001; set_cnt(0, 4); tick(); chk("R10", W'(pin_o), 1, "up above half");
    cnt_up = 3'b000; set_cnt(0, 2); tick(); chk("R10", W'(pin_o), 0, "down below half");
    thr = 6; cnt_up = 3'b001; set_cnt(0, 3); tick(); chk("R10", W'(pin_o), 1, "up at half, lsb clear");

    // R9 / R10 random PWM
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] v, t;
      logic sy, up, e;
      for (int i = 0; i < NC; i++) set_cnt(i, W'($urandom_range(0, 24)));
      sys_time = W'($urandom_range(0, 24));
      cnt_up = 3'($urandom); cnt_sym = 3'($urandom);
      sel = 2'($urandom); inv = 1'($urandom);
      thr = W'($urandom_range(0, 40));
      if (sel == 2'd3) begin v = sys_time; sy = 0; up = 1; end
      else begin v = cnt_val[sel*W +: W]; sy = cnt_sym[sel]; up = cnt_up[sel]; end
      t = thr;
      e = pwm_exp(v, t, sy, up);
      tick();
      chk(sy ? "R10" : "R9", W'(pin_o), W'(e ^ inv), "random pwm");
    end
    inv = 0; cnt_sym = '0; cnt_up = '0;

    // R11 repeating blink
    mode = 4'd0; sel = 2'd1; set_cnt(1, 0); tick(); tick();
    thr = 32'h0000_000D; len = 5'd3; once = 0; mode = 4'd8;
    run_blink(40, "R11");

    // R12 single pass blink
    mode = 4'd0; set_cnt(1, 0); tick(); tick();
    thr = 32'h0000_0003; len = 5'd1; once = 1; mode = 4'd8;
    run_blink(30, "R12");
    chk("R12", W'(pin_o), 0, "held low after single pass");
    chk("R12", W'(pin_oe), 1, "still driving after single pass");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule